// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block watches the control and address lines of an asynchronous SRAM-style bus and looks for a fixed run of six read addresses. When the run completes, it raises a one-cycle request for the nonvolatile controller. The sixth address selects the request: one value asks for a STORE, meaning the SRAM contents are copied to nonvolatile cells, and another asks for a RECALL, meaning the nonvolatile contents are copied back into the SRAM. Software therefore issues these commands with plain read cycles to magic addresses. No dedicated pin or register is needed.

The active-low chip-enable, write-enable and output-enable inputs are asynchronous to the system clock. Each passes through a synchroniser first. A falling edge of the synchronised chip-enable marks one access, and write-enable is sampled at that same point to classify the access as a read or a write. Any write anywhere in the run, or any read of an unexpected address, abandons the run. A read of the first key address is the one exception: when it is the access that breaks the run, it starts a new run. While the controller reports busy, all accesses are ignored.

Top module: `acd_cmd_detect`

## Requirements
- R1: After reset, both request outputs are low. A lone access cannot raise a request.
- R2: Six consecutive reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 give exactly one store request and no recall request.
- R3: The same five reads followed by a read at 0x0C63 give exactly one recall request and no store request. A sixth read at any other address gives neither request.
- R4: Each request is high for exactly one clock cycle, and the two requests are never high in the same cycle.
- R5: A write access (chip-enable falling while write-enable is low) at any point in the run abandons the run, so no request follows from the remaining steps.
- R6: A read at an address other than the next expected one abandons the run.
- R7: A read at 0x0E38 that breaks a run counts as step one of a new run, so a following 0x31C7 through the final address completes a request.
- R8: With the default configuration, the output-enable level has no effect on whether a read counts as a step.
- R9: An access whose chip-enable fall is seen while busy_i is high is ignored and returns the run to step zero.
- R10: An access counts once per chip-enable fall. Holding chip-enable low, or changing the address while it stays low, adds no step.
- R11: A request becomes visible after the third rising clock edge that follows chip-enable going low for the final read. That delay is two synchroniser stages plus the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 15 | Bus address, stable while chip-enable is low |
| ce_ni | input | 1 | Active-low chip-enable, asynchronous |
| we_ni | input | 1 | Active-low write-enable, asynchronous |
| oe_ni | input | 1 | Active-low output-enable, asynchronous |
| busy_i | input | 1 | High while the nonvolatile controller is transferring |
| store_req_o | output | 1 | One-cycle store request |
| recall_req_o | output | 1 | One-cycle recall request |

## Verification
The bench builds the block with its defaults: a 15-bit address, a five-address prefix, two synchroniser stages and output-enable not required. At this size, a write fault, a wrong-address fault and a busy fault can each be placed at every one of the six step positions, with both output-enable levels. A restart can be placed after every prefix length. The sixth address is swept across the whole address space with a fixed stride, plus the two command values. The exact pulse cycle is probed once for R11, with chip-enable held low well past the point of detection.

// File: rtl/acd_pkg.sv
package acd_pkg;
  typedef struct packed {
    logic valid;
    logic write;
    logic oe_act;
  } acc_t;
endpackage

// File: rtl/acd_sync.sv
module acd_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= {WIDTH{RST_VAL}};
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/acd_access_detect.sv
module acd_access_detect
  import acd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ns_i,
  input  logic we_ns_i,
  input  logic oe_ns_i,
  output acc_t acc_o
);
  logic ce_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_prev_q <= 1'b1;
    else ce_prev_q <= ce_ns_i;
  end

  always_comb begin
    acc_o.valid  = ce_prev_q & ~ce_ns_i;
    acc_o.write  = ~we_ns_i;
    acc_o.oe_act = ~oe_ns_i;
  end

  AST_ONE_PER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o.valid |=> !acc_o.valid); // R10
endmodule

// File: rtl/acd_seq_fsm.sv
module acd_seq_fsm
  import acd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned PFX_LEN = 5,
  parameter logic [PFX_LEN-1:0][ADDR_W-1:0] PFX_ADDR = '0,
  parameter logic [ADDR_W-1:0] STORE_ADDR  = '0,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = '1,
  parameter bit REQUIRE_OE = 1'b0,
  localparam int unsigned STEP_W = $clog2(PFX_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_t              acc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  output logic              store_o,
  output logic              recall_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PFX_LEN);

  logic [STEP_W-1:0] step_q, step_d;
  logic              store_q, store_d, recall_q, recall_d;
  logic              read_ok, pfx_hit, first_hit;

  // read qualification variant
  if (REQUIRE_OE) begin : g_oe_req
    assign read_ok = ~acc_i.write & acc_i.oe_act;
  end else begin : g_oe_free
    assign read_ok = ~acc_i.write;
  end

  always_comb begin
    pfx_hit = 1'b0;
    for (int i = 0; i < PFX_LEN; i++)
      if (step_q == STEP_W'(i) && addr_i == PFX_ADDR[i]) pfx_hit = 1'b1;
  end

  assign first_hit = (addr_i == PFX_ADDR[0]);

  always_comb begin
    step_d   = step_q;
    store_d  = 1'b0;
    recall_d = 1'b0;
    if (busy_i) begin
      step_d = '0;
    end else if (acc_i.valid) begin
      if (!read_ok) begin
        step_d = '0;
      end else if (step_q == LAST_STEP) begin
        store_d  = (addr_i == STORE_ADDR);
        recall_d = (addr_i == RECALL_ADDR) && (addr_i != STORE_ADDR);
        step_d   = (!store_d && !recall_d && first_hit) ? STEP_W'(1) : '0;
      end else if (pfx_hit) begin
        step_d = step_q + STEP_W'(1);
      end else if (first_hit) begin
        step_d = STEP_W'(1);
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      store_q  <= 1'b0;
      recall_q <= 1'b0;
    end else begin
      step_q   <= step_d;
      store_q  <= store_d;
      recall_q <= recall_d;
    end
  end

  assign store_o  = store_q;
  assign recall_o = recall_q;

  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({store_q, recall_q})); // R4
  AST_STORE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_q |=> !store_q); // R4
  AST_RECALL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_q |=> !recall_q); // R4
  AST_REQ_FULL_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_q || recall_q) |-> $past(step_q) == LAST_STEP); // R2
  AST_WRITE_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i.valid && acc_i.write) |=> (step_q == '0 && !store_q && !recall_q)); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (step_q == '0 && !store_q && !recall_q)); // R9
  AST_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= LAST_STEP); // R6
endmodule

// File: rtl/acd_cmd_detect.sv
module acd_cmd_detect
  import acd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned PFX_LEN     = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [PFX_LEN-1:0][ADDR_W-1:0] PFX_ADDR =
    {15'h303F, 15'h3C1F, 15'h03E0, 15'h31C7, 15'h0E38},
  parameter logic [ADDR_W-1:0] STORE_ADDR  = 15'h0FC0,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = 15'h0C63,
  parameter bit REQUIRE_OE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              busy_i,
  output logic              store_req_o,
  output logic              recall_req_o
);
  logic [2:0] ctl_s;
  acc_t       acc;

  acd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({oe_ni, we_ni, ce_ni}),
    .q_o   (ctl_s)
  );

  acd_access_detect u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_ns_i(ctl_s[0]),
    .we_ns_i(ctl_s[1]),
    .oe_ns_i(ctl_s[2]),
    .acc_o  (acc)
  );

  acd_seq_fsm #(
    .ADDR_W     (ADDR_W),
    .PFX_LEN    (PFX_LEN),
    .PFX_ADDR   (PFX_ADDR),
    .STORE_ADDR (STORE_ADDR),
    .RECALL_ADDR(RECALL_ADDR),
    .REQUIRE_OE (REQUIRE_OE)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .addr_i  (addr_i),
    .busy_i  (busy_i),
    .store_o (store_req_o),
    .recall_o(recall_req_o)
  );
endmodule

// File: tb/acd_cmd_detect_bench.sv
module acd_cmd_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] addr = '0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic        st, rc;

  int checks = 0, errors = 0;
  int st_cnt = 0, rc_cnt = 0, both_cnt = 0;
  bit done = 0;

  logic [14:0] keys [6] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0FC0};
  localparam logic [14:0] STORE_A = 15'h0FC0, RECALL_A = 15'h0C63;

  always #10 clk = ~clk;

  acd_cmd_detect u_acd_cmd_detect (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce_ni(ce_n), .we_ni(we_n),
    .oe_ni(oe_n), .busy_i(busy), .store_req_o(st), .recall_req_o(rc)
  );

  always @(negedge clk) if (rst_n) begin
    st_cnt += int'(st);
    rc_cnt += int'(rc);
    if (st && rc) both_cnt++;
  end

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic access(logic [14:0] a, bit wr, bit oe, bit bz);
    @(negedge clk);
    addr = a; we_n = ~wr; oe_n = ~oe; busy = bz;
    @(negedge clk);
    ce_n = 1'b0;
    repeat (4) @(negedge clk);
    ce_n = 1'b1;
    repeat (4) @(negedge clk);
    we_n = 1'b1; busy = 1'b0;
  endtask

  task automatic clr();
    repeat (2) @(negedge clk);
    st_cnt = 0; rc_cnt = 0;
  endtask

  // fault kinds: 1 write, 2 wrong read, 3 busy
  task automatic fault_run(int pos, int kind, bit oe, logic [14:0] term, string tag);
    int exp_st, exp_rc;
    logic [14:0] k;
    clr();
    for (int i = 0; i < pos; i++) access(keys[i], 0, oe, 0);
    k = (pos == 5) ? term : keys[pos];
    case (kind)
      1: access(k, 1, oe, 0);
      2: access(k ^ 15'h4000, 0, oe, 0);
      default: access(k, 0, oe, 1);
    endcase
    for (int i = pos; i < 6; i++) access((i == 5) ? term : keys[i], 0, oe, 0);
    repeat (4) @(negedge clk);
    exp_st = (pos == 0 && term == STORE_A) ? 1 : 0;
    exp_rc = (pos == 0 && term == RECALL_A) ? 1 : 0;
    chk(st_cnt, exp_st, tag);
    chk(rc_cnt, exp_rc, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(int'(st), 0, "R1 store low after reset");
    chk(int'(rc), 0, "R1 recall low after reset");
    clr();
    access(15'h0E38, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk(st_cnt + rc_cnt, 0, "R1 lone access no request");

    // R2/R3/R8: clean runs, both OE levels
    for (int oe = 0; oe < 2; oe++) begin
      clr();
      for (int i = 0; i < 6; i++) access(keys[i], 0, oe[0], 0);
      repeat (4) @(negedge clk);
      chk(st_cnt, 1, "R2 R8 store count");
      chk(rc_cnt, 0, "R2 R8 no recall");
      clr();
      for (int i = 0; i < 5; i++) access(keys[i], 0, oe[0], 0);
      access(RECALL_A, 0, oe[0], 0);
      repeat (4) @(negedge clk);
      chk(rc_cnt, 1, "R3 R8 recall count");
      chk(st_cnt, 0, "R3 R8 no store");
    end

    // R3: sweep of sixth address
    for (int a = 0; a < 32768; a += 257) begin
      logic [14:0] t;
      t = 15'(a);
      clr();
      for (int i = 0; i < 5; i++) access(keys[i], 0, 0, 0);
      access(t, 0, 0, 0);
      repeat (4) @(negedge clk);
      chk(st_cnt, (t == STORE_A) ? 1 : 0, "R3 sweep store");
      chk(rc_cnt, (t == RECALL_A) ? 1 : 0, "R3 sweep recall");
    end

    // R5/R6/R9: faults at every step
    for (int p = 0; p < 6; p++) begin
      fault_run(p, 1, p[0], STORE_A, "R5 write abort");
      fault_run(p, 2, p[0], RECALL_A, "R6 wrong read abort");
      fault_run(p, 3, ~p[0], STORE_A, "R9 busy ignore");
    end

    // R7: restart after every prefix length
    for (int p = 1; p < 6; p++) begin
      clr();
      for (int i = 0; i < p; i++) access(keys[i], 0, 0, 0);
      access(15'h0E38, 0, 0, 0);
      for (int i = 1; i < 6; i++) access(keys[i], 0, 0, 0);
      repeat (4) @(negedge clk);
      chk(st_cnt, 1, "R7 restart store");
    end

    // R11/R10/R4: exact cycle, long CE low with address change
    clr();
    for (int i = 0; i < 5; i++) access(keys[i], 0, 0, 0);
    @(negedge clk);
    addr = STORE_A;
    @(negedge clk);
    ce_n = 1'b0;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      chk(int'(st), (n == 3) ? 1 : 0, "R11 R4 pulse cycle");
      if (n == 4) addr = 15'h0E38;
    end
    repeat (10) @(negedge clk);
    ce_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(st_cnt, 1, "R10 R4 single pulse with long CE low");
    clr();
    for (int i = 1; i < 6; i++) access(keys[i], 0, 0, 0);
    repeat (4) @(negedge clk);
    chk(st_cnt, 0, "R10 address change during CE low not counted");
    chk(both_cnt, 0, "R4 never both requests");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule